// File: doc/BRIEF.md
# Hypervisor Exception Entry Sequencer

This block performs the state update that takes a 32-bit processor into its hypervisor mode when a trap or interrupt is routed to that privilege level. A single-cycle request strobe carries an exception-type code together with a snapshot of the surrounding state. That snapshot holds the current level, the three routing-control bits, the hypervisor vector base, the current program counter, the live status word, a syndrome value and a fault address. It also holds the two control bits that select endianness and instruction set on entry.

On the clock edge that samples the strobe, the block does all of the entry work at once. It picks a vector offset from the exception type and folds that offset to the shared trap entry when the exception did not come from the hypervisor level. It adds the offset to the vector base and builds the new status word. It saves the old status with its single-step bit cleared and stores the return address. Where the exception type calls for it, it also records the syndrome and the fault address. A done pulse marks the cycle in which the new values appear. An unknown code sets a sticky error flag and leaves every stored value as it was.

Top module: `hyp_entry_ctrl`

## Requirements
- R1: When the current level is the hypervisor level, the vector offset depends on the code. Undefined instruction (code 0) uses 0x04. Hypervisor call (1) uses 0x08. Prefetch abort (2) and breakpoint (3) use 0x0C. Data abort (4) uses 0x10. Supervisor call (5) and hypervisor trap (6) use 0x14. IRQ (7) uses 0x18 and FIQ (8) uses 0x1C.
- R2: When the current level is not the hypervisor level, any offset below 0x14 is replaced by 0x14. Larger offsets are kept.
- R3: `new_pc` becomes `vbar` plus the offset, taken modulo 2^ADDR_W.
- R4: In the status word, A is bit 8, I is bit 7 and F is bit 6. A is set when `route_ea` is 0, I is set when `route_irq` is 0 and F is set when `route_fiq` is 0. A mask bit that is already set in the incoming status stays set.
- R5: Every valid code except IRQ and FIQ loads `syndrome` into `syn_reg`. IRQ and FIQ leave `syn_reg` unchanged.
- R6: Prefetch abort and breakpoint load `fault_addr` into `ifa_reg`. Data abort loads it into `dfa_reg`. Every other code leaves both registers unchanged.
- R7: `link_ret` receives `pc_in` with no offset added.
- R8: The single-step bit is bit 21. It is 0 in both `saved_status` and `new_status`, and every other bit of `saved_status` equals the incoming status.
- R9: The new status word is built as follows. The conditional-execution bits [26:25] and [15:10] are cleared. The mode field [4:0] becomes 5'b11010. E (bit 9) is loaded from `ctl_ee` and T (bit 5) from `ctl_te`. Bits not named here keep their incoming value.
- R10: Codes 9 to 15 set `err`. The flag stays set until reset, and no other output register changes.
- R11: After reset every output is 0. `done` is high for exactly the one cycle after a strobe that carries a valid code, and the new values appear in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Single-cycle entry request |
| exc_code | input | 4 | Exception type code |
| cur_hyp | input | 1 | Current level is the hypervisor level |
| route_ea | input | 1 | External-abort routing bit |
| route_irq | input | 1 | IRQ routing bit |
| route_fiq | input | 1 | FIQ routing bit |
| ctl_ee | input | 1 | Endianness selected on entry |
| ctl_te | input | 1 | Instruction-set bit selected on entry |
| vbar | input | ADDR_W | Hypervisor vector base |
| pc_in | input | ADDR_W | Preferred return address |
| status_in | input | 32 | Live status word |
| syndrome | input | SYN_W | Syndrome value |
| fault_addr | input | ADDR_W | Faulting virtual address |
| done | output | 1 | Entry completed this cycle |
| err | output | 1 | Sticky unknown-code flag |
| new_pc | output | ADDR_W | Target program counter |
| new_status | output | 32 | Status word after entry |
| saved_status | output | 32 | Saved copy of the old status |
| link_ret | output | ADDR_W | Hypervisor exception-link value |
| syn_reg | output | SYN_W | Hypervisor syndrome register |
| ifa_reg | output | ADDR_W | Instruction-fault address register |
| dfa_reg | output | ADDR_W | Data-fault address register |

## Verification
The bench builds the block with ADDR_W = 32 and SYN_W = 25. The narrower syndrome checks that the syndrome path follows its own width rather than the address width. Vector bases close to 2^32 make the base-plus-offset sum wrap, so the modulo behaviour of R3 is exercised at the top of the address range. Every code is driven from both privilege levels, and every combination of the three routing bits is applied. Runs of back-to-back strobes show that each entry starts from the state the previous entry left behind.

// File: rtl/hyp_entry_ctrl.sv
module hyp_entry_ctrl #(
  parameter int ADDR_W = 32,
  parameter int SYN_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [3:0]        exc_code,
  input  logic              cur_hyp,
  input  logic              route_ea,
  input  logic              route_irq,
  input  logic              route_fiq,
  input  logic              ctl_ee,
  input  logic              ctl_te,
  input  logic [ADDR_W-1:0] vbar,
  input  logic [ADDR_W-1:0] pc_in,
  input  logic [31:0]       status_in,
  input  logic [SYN_W-1:0]  syndrome,
  input  logic [ADDR_W-1:0] fault_addr,
  output logic              done,
  output logic              err,
  output logic [ADDR_W-1:0] new_pc,
  output logic [31:0]       new_status,
  output logic [31:0]       saved_status,
  output logic [ADDR_W-1:0] link_ret,
  output logic [SYN_W-1:0]  syn_reg,
  output logic [ADDR_W-1:0] ifa_reg,
  output logic [ADDR_W-1:0] dfa_reg
);
  localparam logic [4:0] HYP_MODE = 5'b11010;
  localparam int SS_BIT = 21;
  localparam logic [3:0] C_UND = 4'd0, C_HVC = 4'd1, C_PABT = 4'd2, C_BKPT = 4'd3,
                         C_DABT = 4'd4, C_SVC = 4'd5, C_TRAP = 4'd6, C_IRQ = 4'd7,
                         C_FIQ = 4'd8;

  logic [7:0] raw_off, off;
  logic known;

  always_comb begin
    known = 1'b1;
    unique case (exc_code)
      C_UND:          raw_off = 8'h04;
      C_HVC:          raw_off = 8'h08;
      C_PABT, C_BKPT: raw_off = 8'h0C;
      C_DABT:         raw_off = 8'h10;
      C_SVC, C_TRAP:  raw_off = 8'h14;
      C_IRQ:          raw_off = 8'h18;
      C_FIQ:          raw_off = 8'h1C;
      default: begin
        raw_off = 8'h00;
        known   = 1'b0;
      end
    endcase
  end

  assign off = (!cur_hyp && raw_off < 8'h14) ? 8'h14 : raw_off;

  logic        fire, is_async, is_ifault, is_dfault;
  logic [31:0] st_noss, st_entry;

  assign fire      = req && known;
  assign is_async  = (exc_code == C_IRQ) || (exc_code == C_FIQ);
  assign is_ifault = (exc_code == C_PABT) || (exc_code == C_BKPT);
  assign is_dfault = (exc_code == C_DABT);

  always_comb begin
    st_noss         = status_in;
    st_noss[SS_BIT] = 1'b0;
    st_entry        = st_noss;
    st_entry[26:25] = 2'b00;
    st_entry[15:10] = 6'b0;
    st_entry[4:0]   = HYP_MODE;
    st_entry[9]     = ctl_ee;
    st_entry[5]     = ctl_te;
    st_entry[8]     = status_in[8] | ~route_ea;
    st_entry[7]     = status_in[7] | ~route_irq;
    st_entry[6]     = status_in[6] | ~route_fiq;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done         <= 1'b0;
      err          <= 1'b0;
      new_pc       <= '0;
      new_status   <= '0;
      saved_status <= '0;
      link_ret     <= '0;
      syn_reg      <= '0;
      ifa_reg      <= '0;
      dfa_reg      <= '0;
    end else begin
      done <= fire;
      if (req && !known) err <= 1'b1;
      if (fire) begin
        new_pc       <= vbar + ADDR_W'(off);
        new_status   <= st_entry;
        saved_status <= st_noss;
        link_ret     <= pc_in;
        if (!is_async)  syn_reg <= syndrome;
        if (is_ifault)  ifa_reg <= fault_addr;
        if (is_dfault)  dfa_reg <= fault_addr;
      end
    end
  end
endmodule

// File: rtl/hyp_entry_chk.sv
module hyp_entry_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req,
  input logic              cur_hyp,
  input logic [ADDR_W-1:0] vbar,
  input logic [ADDR_W-1:0] pc_in,
  input logic [31:0]       status_in,
  input logic              done,
  input logic              err,
  input logic [ADDR_W-1:0] new_pc,
  input logic [31:0]       new_status,
  input logic [31:0]       saved_status,
  input logic [ADDR_W-1:0] link_ret
);
  AST_DONE_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(req)); // R11
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err); // R10
  AST_SHARED_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !$past(cur_hyp)) |-> ((new_pc - $past(vbar)) == ADDR_W'(8'h14) ||
                                  (new_pc - $past(vbar)) == ADDR_W'(8'h18) ||
                                  (new_pc - $past(vbar)) == ADDR_W'(8'h1C))); // R2
  AST_MASKS_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((new_status[8:6] & $past(status_in[8:6])) == $past(status_in[8:6]))); // R4
  AST_ZERO_RET_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (link_ret == $past(pc_in))); // R7
  AST_STEP_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!saved_status[21] && !new_status[21])); // R8
  AST_HYP_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (new_status[4:0] == 5'b11010)); // R9
endmodule

bind hyp_entry_ctrl hyp_entry_chk #(.ADDR_W(ADDR_W)) u_hyp_entry_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .cur_hyp(cur_hyp), .vbar(vbar),
  .pc_in(pc_in), .status_in(status_in), .done(done), .err(err),
  .new_pc(new_pc), .new_status(new_status), .saved_status(saved_status),
  .link_ret(link_ret)
);

// File: tb/test_hyp_entry_ctrl.sv
`timescale 1ns/1ps
module test_hyp_entry_ctrl;
  localparam int AW = 32;
  localparam int SW = 25;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0;
  logic [3:0] exc_code = '0;
  logic cur_hyp = 1'b0, route_ea = 1'b0, route_irq = 1'b0, route_fiq = 1'b0;
  logic ctl_ee = 1'b0, ctl_te = 1'b0;
  logic [AW-1:0] vbar = '0, pc_in = '0, fault_addr = '0;
  logic [31:0] status_in = '0;
  logic [SW-1:0] syndrome = '0;
  logic done, err;
  logic [AW-1:0] new_pc, link_ret, ifa_reg, dfa_reg;
  logic [31:0] new_status, saved_status;
  logic [SW-1:0] syn_reg;

  always #2 clk = ~clk;

  hyp_entry_ctrl #(.ADDR_W(AW), .SYN_W(SW)) i_hyp_entry_ctrl (
    .clk(clk), .rst_n(rst_n), .req(req), .exc_code(exc_code), .cur_hyp(cur_hyp),
    .route_ea(route_ea), .route_irq(route_irq), .route_fiq(route_fiq),
    .ctl_ee(ctl_ee), .ctl_te(ctl_te), .vbar(vbar), .pc_in(pc_in),
    .status_in(status_in), .syndrome(syndrome), .fault_addr(fault_addr),
    .done(done), .err(err), .new_pc(new_pc), .new_status(new_status),
    .saved_status(saved_status), .link_ret(link_ret), .syn_reg(syn_reg),
    .ifa_reg(ifa_reg), .dfa_reg(dfa_reg));

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  logic e_done = 0, e_err = 0;
  logic [AW-1:0] e_pc = 0, e_link = 0, e_ifa = 0, e_dfa = 0;
  logic [31:0] e_st = 0, e_sv = 0;
  logic [SW-1:0] e_syn = 0;
  int last_off = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int vec_off(input int code, input bit hyp);
    int o;
    case (code)
      0: o = 4; 1: o = 8; 2, 3: o = 12; 4: o = 16;
      5, 6: o = 20; 7: o = 24; 8: o = 28;
      default: o = -1;
    endcase
    if (!hyp && o >= 0 && o < 20) o = 20;
    return o;
  endfunction

  task automatic compare_all();
    chk("R11 done", 64'(done), 64'(e_done));
    chk("R10 err", 64'(err), 64'(e_err));
    chk("R3 new_pc", 64'(new_pc), 64'(e_pc));
    chk("R9 new_status", 64'(new_status), 64'(e_st));
    chk("R8 saved_status", 64'(saved_status), 64'(e_sv));
    chk("R7 link_ret", 64'(link_ret), 64'(e_link));
    chk("R5 syn_reg", 64'(syn_reg), 64'(e_syn));
    chk("R6 ifa_reg", 64'(ifa_reg), 64'(e_ifa));
    chk("R6 dfa_reg", 64'(dfa_reg), 64'(e_dfa));
  endtask

  task automatic model_step();
    int o;
    logic [31:0] s;
    e_done = 1'b0;
    if (!rst_n) begin
      e_err = 0; e_pc = 0; e_st = 0; e_sv = 0; e_link = 0; e_syn = 0; e_ifa = 0; e_dfa = 0;
      return;
    end
    if (!req) return;
    o = vec_off(int'(exc_code), cur_hyp);
    if (o < 0) begin
      e_err = 1'b1;
      return;
    end
    e_done = 1'b1;
    last_off = o;
    e_pc = vbar + AW'(o);
    s = status_in;
    s[21] = 1'b0;
    e_sv = s;
    s[26:25] = 0; s[15:10] = 0; s[4:0] = 5'b11010;
    s[9] = ctl_ee; s[5] = ctl_te;
    if (!route_ea) s[8] = 1'b1;
    if (!route_irq) s[7] = 1'b1;
    if (!route_fiq) s[6] = 1'b1;
    e_st = s;
    e_link = pc_in;
    if (exc_code != 7 && exc_code != 8) e_syn = syndrome;
    if (exc_code == 2 || exc_code == 3) e_ifa = fault_addr;
    if (exc_code == 4) e_dfa = fault_addr;
  endtask

  task automatic cyc();
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  task automatic entry(input int code, input bit hyp, input logic [2:0] rt,
                       input logic [AW-1:0] base, input logic [31:0] st);
    req = 1'b1; exc_code = 4'(code); cur_hyp = hyp;
    {route_ea, route_irq, route_fiq} = rt;
    vbar = base; status_in = st;
    pc_in = $urandom; fault_addr = $urandom; syndrome = SW'($urandom);
    ctl_ee = 1'($urandom); ctl_te = 1'($urandom);
    cyc();
  endtask

  task automatic idle();
    req = 1'b0; exc_code = 4'($urandom); pc_in = $urandom;
    fault_addr = $urandom; syndrome = SW'($urandom); status_in = $urandom;
    cyc();
  endtask

  initial begin
    #400000;
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    repeat (3) cyc();
    rst_n = 1'b1;
    cyc();
    // R11 reset state already compared; directed offsets from hypervisor level
    for (int c = 0; c < 9; c++) begin
      entry(c, 1'b1, 3'b111, 32'h8000_0000, 32'h0000_0010);
      chk("R1 offset hyp", 64'(new_pc - 32'h8000_0000), 64'(vec_off(c, 1'b1)));
      idle();
    end
    // R2 collapse from lower levels
    for (int c = 0; c < 9; c++) begin
      entry(c, 1'b0, 3'b111, 32'h0001_0000, 32'h0000_0013);
      chk("R2 offset non-hyp", 64'(new_pc - 32'h0001_0000), 64'(last_off));
    end
    // R4 every routing combination, masks clear then preset
    for (int r = 0; r < 8; r++) begin
      entry(7, 1'b1, 3'(r), 32'h4000_0000, 32'hFFFF_FE3F);
      entry(8, 1'b0, 3'(r), 32'h4000_0000, 32'h0000_01C0);
    end
    // R3 wrap at top of address space
    entry(8, 1'b0, 3'b000, 32'hFFFF_FFF0, 32'h0620_FC00);
    chk("R3 wrap", 64'(new_pc), 64'(32'h0000_000C));
    // R10 unknown codes, back to back, then valid again
    for (int c = 9; c < 16; c++) entry(c, 1'($urandom), 3'($urandom), $urandom, $urandom);
    chk("R10 err sticky", 64'(err), 64'd1);
    idle();
    // back-to-back random mix
    for (int i = 0; i < 400; i++) begin
      if ($urandom % 4 == 0) idle();
      else entry(int'($urandom % 16), 1'($urandom), 3'($urandom), $urandom, $urandom);
    end
    // reset clears sticky error
    rst_n = 1'b0; req = 1'b0;
    cyc();
    rst_n = 1'b1;
    cyc();
    chk("R11 reset err", 64'(err), 64'd0);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule